// File: doc/BRIEF.md
# Multi-Width 128-Bit Integer Add/Shift Unit

This unit is the add, subtract and shift datapath for a core whose integer registers are 128 bits wide. Each cycle it may accept one 32-bit instruction word and the two source register values, each given as a low and a high 64-bit half. It decodes the instruction, computes the result and registers it together with the destination index and an illegal flag. The result appears one cycle after the input strobe.

Three operand widths are handled. Full-width operations work on all 128 bits. Doubleword operations work on the low 64 bits and sign-extend from bit 63. Word operations work on the low 32 bits and sign-extend from bit 31 through all 128 bits. The width picks which source bits take part, how the shift amount is masked, and how far the result is sign-extended. Doubleword operations exist only while the core runs with 128-bit registers, which is given by an input.

Top module: `wide_int_alu`

## Requirements
- R1: Full-width operations use opcode 0110011 (register form, funct7 0000000 for add and 0100000 for subtract, funct3 000) or 0010011 (immediate add, funct3 000). They compute on all 128 bits. The carry or borrow passes from bit 63 into bit 64.
- R2: Doubleword operations use opcode 1111011 (register form; funct3 000 with funct7 0000000 for add and 0100000 for subtract) or 1011011 (immediate form, funct3 000 for add-immediate). They compute modulo 2^64, and the carry out of bit 63 is dropped. The 12-bit immediate in bits 31:20 is sign-extended before the add.
- R3: For doubleword and word operations, bits 127:64 of both sources have no effect on the result.
- R4: A doubleword result has bits 127:64 equal to copies of bit 63. A word result (opcodes 0111011 register form, 0011011 immediate form) has bits 127:32 equal to copies of bit 31.
- R5: Shifts use funct3 001 for left and 101 for right, with instruction bit 30 selecting arithmetic right. The amount comes from the low bits of source 2 or from instruction bits 26:20. It is masked to 7 bits at full width, to 6 bits for doubleword and to 5 bits for word.
- R6: A doubleword opcode with the 128-bit-mode input low is flagged illegal. Any other opcode, funct3 or funct7 combination not listed in R1, R2, R4 or R5 is also flagged illegal. An illegal result is zero in both halves.
- R7: A source index of 0 (bits 19:15 or 24:20) reads as zero in both halves, whatever is on the source inputs. A destination index of 0 (bits 11:7) produces a zero result.
- R8: Result, destination index and illegal flag are registered. out_valid is high exactly one cycle after in_valid. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and sources present this cycle |
| mode128 | input | 1 | Core is running with 128-bit registers |
| instr | input | 32 | Instruction word |
| src1_lo | input | 64 | Source 1 bits 63:0 |
| src1_hi | input | 64 | Source 1 bits 127:64 |
| src2_lo | input | 64 | Source 2 bits 63:0 |
| src2_hi | input | 64 | Source 2 bits 127:64 |
| out_valid | output | 1 | Registered result valid |
| out_illegal | output | 1 | Instruction was not accepted |
| out_rd | output | 5 | Destination register index |
| out_lo | output | 64 | Result bits 63:0 |
| out_hi | output | 64 | Result bits 127:64 |

## Verification
Directed patterns come first. A low half of all ones plus one separates a full-width add, which must carry into the high half, from a doubleword add, which must not. Garbage placed in the source high halves of narrow operations shows whether those bits leak into the result. Shift amounts with bits set above the mask (0xFF, 0x7F, 0x3F) make the three masks give three different results. Values just below a sign boundary show whether the result is extended from bit 63 or from bit 31. Doubleword opcodes sent with 128-bit mode off, and indices of zero, cover gating and the zero register. A random mix of valid and malformed encodings is then checked against a behavioural model.

// File: rtl/wide_int_alu.sv
module wide_int_alu #(
  parameter int HALF = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            mode128,
  input  logic [31:0]     instr,
  input  logic [HALF-1:0] src1_lo,
  input  logic [HALF-1:0] src1_hi,
  input  logic [HALF-1:0] src2_lo,
  input  logic [HALF-1:0] src2_hi,
  output logic            out_valid,
  output logic            out_illegal,
  output logic [4:0]      out_rd,
  output logic [HALF-1:0] out_lo,
  output logic [HALF-1:0] out_hi
);
  localparam int FULL = 2 * HALF;
  localparam int SHW  = $clog2(FULL);

  localparam logic [6:0] OP_R  = 7'b0110011, OP_I  = 7'b0010011;
  localparam logic [6:0] OP_RW = 7'b0111011, OP_IW = 7'b0011011;
  localparam logic [6:0] OP_RD = 7'b1111011, OP_ID = 7'b1011011;

  typedef enum logic [1:0] {WQ, WD, WW} width_e;

  logic [6:0] op;
  logic [2:0] f3;
  logic [6:0] f7;
  logic [4:0] rd, rs1, rs2;
  assign op  = instr[6:0];
  assign rd  = instr[11:7];
  assign f3  = instr[14:12];
  assign rs1 = instr[19:15];
  assign rs2 = instr[24:20];
  assign f7  = instr[31:25];

  logic is_r, is_i, known;
  width_e wid;
  assign is_r  = (op == OP_R) || (op == OP_RW) || (op == OP_RD);
  assign is_i  = (op == OP_I) || (op == OP_IW) || (op == OP_ID);
  assign known = is_r || is_i;
  assign wid   = (op == OP_RD || op == OP_ID) ? WD :
                 (op == OP_RW || op == OP_IW) ? WW : WQ;

  logic imm_sh_low_ok, funct_ok;
  assign imm_sh_low_ok = (wid == WQ) || (wid == WD && !instr[26]) ||
                         (wid == WW && instr[26:25] == 2'b00);

  always_comb begin
    funct_ok = 1'b0;
    case (f3)
      3'b000: funct_ok = is_i || (f7 == 7'b0000000) || (f7 == 7'b0100000);
      3'b001: funct_ok = is_r ? (f7 == 7'b0000000)
                              : (instr[31:27] == 5'b00000) && imm_sh_low_ok;
      3'b101: funct_ok = is_r ? ((f7 == 7'b0000000) || (f7 == 7'b0100000))
                              : ((instr[31:27] == 5'b00000) || (instr[31:27] == 5'b01000))
                                && imm_sh_low_ok;
      default: funct_ok = 1'b0;
    endcase
  end

  logic illegal;
  assign illegal = !known || !funct_ok || (wid == WD && !mode128);

  logic [FULL-1:0] a, b, imm, opb, a_n, b_n;
  assign a   = (rs1 == 5'd0) ? '0 : {src1_hi, src1_lo};
  assign b   = (rs2 == 5'd0) ? '0 : {src2_hi, src2_lo};
  assign imm = {{(FULL-12){instr[31]}}, instr[31:20]};
  assign opb = is_r ? b : imm;
  assign a_n = (wid == WQ) ? a   : {{HALF{1'b0}}, a[HALF-1:0]};
  assign b_n = (wid == WQ) ? opb : {{HALF{1'b0}}, opb[HALF-1:0]};

  logic [SHW-1:0] amt;
  assign amt = (wid == WQ) ? opb[SHW-1:0] :
               (wid == WD) ? {1'b0, opb[SHW-2:0]} : {2'b00, opb[SHW-3:0]};

  logic arith;
  logic [FULL-1:0] sh_src;
  assign arith  = instr[30];
  assign sh_src = (wid == WQ) ? a :
                  (wid == WD) ? {{HALF{arith & a[HALF-1]}}, a[HALF-1:0]}
                              : {{(FULL-32){arith & a[31]}}, a[31:0]};

  logic [FULL-1:0] raw, res;
  always_comb begin
    case (f3)
      3'b001:  raw = a_n << amt;
      3'b101:  raw = arith ? FULL'($signed(sh_src) >>> amt) : (sh_src >> amt);
      default: raw = (is_r && f7[5]) ? (a_n - b_n) : (a_n + b_n);
    endcase
    case (wid)
      WD:      res = {{HALF{raw[HALF-1]}}, raw[HALF-1:0]};
      WW:      res = {{(FULL-32){raw[31]}}, raw[31:0]};
      default: res = raw;
    endcase
    if (illegal || rd == 5'd0) res = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_rd      <= '0;
      out_lo      <= '0;
      out_hi      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_illegal <= illegal;
        out_rd      <= rd;
        out_lo      <= res[HALF-1:0];
        out_hi      <= res[FULL-1:HALF];
      end
    end
  end
endmodule

// File: rtl/wide_int_alu_chk.sv
module wide_int_alu_chk #(
  parameter int HALF = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            mode128,
  input logic [31:0]     instr,
  input logic            out_valid,
  input logic            out_illegal,
  input logic [HALF-1:0] out_lo,
  input logic [HALF-1:0] out_hi
);
  logic dword_op, word_op;
  assign dword_op = (instr[6:0] == 7'b1111011) || (instr[6:0] == 7'b1011011);
  assign word_op  = (instr[6:0] == 7'b0111011) || (instr[6:0] == 7'b0011011);

  p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_dword_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode128 && dword_op) |=> out_illegal);
  p_illegal_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_lo == '0 && out_hi == '0));
  p_rd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[11:7] == 5'd0) |=> (out_lo == '0 && out_hi == '0));
  p_narrow_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (dword_op || word_op)) |=> (out_hi == {HALF{out_lo[HALF-1]}}));
  p_word_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && word_op) |=> (out_lo[HALF-1:32] == {(HALF-32){out_lo[31]}}));
endmodule

bind wide_int_alu wide_int_alu_chk #(.HALF(HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode128(mode128),
  .instr(instr), .out_valid(out_valid), .out_illegal(out_illegal),
  .out_lo(out_lo), .out_hi(out_hi)
);

// File: tb/test_wide_int_alu.sv
`timescale 1ns/1ps
module test_wide_int_alu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, mode128 = 1'b1;
  logic [31:0] instr = '0;
  logic [63:0] s1l = '0, s1h = '0, s2l = '0, s2h = '0;
  logic out_valid, out_illegal;
  logic [4:0] out_rd;
  logic [63:0] out_lo, out_hi;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  wide_int_alu i_wide_int_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode128(mode128),
    .instr(instr), .src1_lo(s1l), .src1_hi(s1h), .src2_lo(s2l), .src2_hi(s2h),
    .out_valid(out_valid), .out_illegal(out_illegal), .out_rd(out_rd),
    .out_lo(out_lo), .out_hi(out_hi));

  function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] r2, logic [4:0] r1,
                                        logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {f7, r2, r1, f3, rd, op};
  endfunction
  function automatic logic [31:0] enc_i(logic [11:0] im, logic [4:0] r1,
                                        logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {im, r1, f3, rd, op};
  endfunction

  function automatic logic [127:0] sx(logic [127:0] x, int n);
    if (n == 64) return {{64{x[63]}}, x[63:0]};
    if (n == 32) return {{96{x[31]}}, x[31:0]};
    return x;
  endfunction

  // Behavioural reference: returns {illegal, result}
  function automatic logic [128:0] model(logic [31:0] ins, logic m128,
                                         logic [127:0] x, logic [127:0] y);
    int n; bit reg_form, ok; int amt;
    logic [127:0] a, b, r;
    logic [6:0] op = ins[6:0];
    logic [2:0] f3 = ins[14:12];
    logic [6:0] f7 = ins[31:25];
    case (op)
      7'b0110011: begin n = 128; reg_form = 1; end
      7'b0010011: begin n = 128; reg_form = 0; end
      7'b1111011: begin n = 64;  reg_form = 1; end
      7'b1011011: begin n = 64;  reg_form = 0; end
      7'b0111011: begin n = 32;  reg_form = 1; end
      7'b0011011: begin n = 32;  reg_form = 0; end
      default:    return {1'b1, 128'd0};
    endcase
    if (n == 64 && !m128) return {1'b1, 128'd0};
    a = (ins[19:15] == 0) ? 128'd0 : x;
    if (reg_form) b = (ins[24:20] == 0) ? 128'd0 : y;
    else b = {{116{ins[31]}}, ins[31:20]};
    if (n < 128) begin a[127:64] = '0; b[127:64] = '0; end
    amt = int'(b[6:0]) % n;
    ok = 0; r = '0;
    if (f3 == 3'b000) begin
      if (!reg_form) begin ok = 1; r = a + b; end
      else if (f7 == 0) begin ok = 1; r = a + b; end
      else if (f7 == 7'h20) begin ok = 1; r = a - b; end
    end else if (f3 == 3'b001) begin
      if (reg_form) ok = (f7 == 0);
      else ok = (ins[31:27] == 0) && (n != 64 || !ins[26]) && (n != 32 || ins[26:25] == 0);
      r = a << amt;
    end else if (f3 == 3'b101) begin
      if (reg_form) ok = (f7 == 0) || (f7 == 7'h20);
      else ok = (ins[31:27] == 0 || ins[31:27] == 5'b01000) &&
                (n != 64 || !ins[26]) && (n != 32 || ins[26:25] == 0);
      if (ins[30]) r = 128'($signed(sx(a, n)) >>> amt);
      else begin
        if (n == 32) a[63:32] = '0;
        r = a >> amt;
      end
    end
    if (!ok) return {1'b1, 128'd0};
    r = sx(r, n);
    if (ins[11:7] == 0) r = '0;
    return {1'b0, r};
  endfunction

  task automatic chk(string tag, bit cond, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive one instruction, compare to model (and optional fixed expectation)
  task automatic run(string tag, logic [31:0] ins, logic m, logic [127:0] x, logic [127:0] y,
                     bit use_exp = 0, bit e_ill = 0, logic [127:0] e_res = '0);
    logic [128:0] ref_v;
    @(negedge clk);
    instr = ins; mode128 = m; in_valid = 1'b1;
    {s1h, s1l} = x; {s2h, s2l} = y;
    ref_v = model(ins, m, x, y);
    @(negedge clk);
    in_valid = 1'b0;
    instr = $urandom; {s1h, s1l} = {$urandom, $urandom, $urandom, $urandom};
    chk(tag, out_valid == 1'b1, "valid", 128'(out_valid), 128'd1);
    chk(tag, out_rd == ins[11:7], "rd", 128'(out_rd), 128'(ins[11:7]));
    chk(tag, out_illegal == ref_v[128], "illegal", 128'(out_illegal), 128'(ref_v[128]));
    chk(tag, {out_hi, out_lo} == ref_v[127:0], "result", {out_hi, out_lo}, ref_v[127:0]);
    if (use_exp) begin
      chk(tag, out_illegal == e_ill, "illegal(fixed)", 128'(out_illegal), 128'(e_ill));
      chk(tag, {out_hi, out_lo} == e_res, "result(fixed)", {out_hi, out_lo}, e_res);
    end
    @(negedge clk);
    chk("R8", out_valid == 1'b0, "idle valid", 128'(out_valid), 128'd0);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_up();
  end

  localparam logic [127:0] ONES = '1;
  localparam logic [127:0] JUNK = {64'hDEAD_BEEF_0BAD_F00D, 64'h0};

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", out_valid == 0 && out_illegal == 0 && out_rd == 0, "reset ctl",
        {out_valid, out_illegal, out_rd}, 128'd0);
    chk("R8", out_lo == 0 && out_hi == 0, "reset data", {out_hi, out_lo}, 128'd0);
    rst_n = 1'b1;

    // R1 full-width carry and borrow across halves
    run("R1", enc_r(7'h00, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011), 1,
        {64'd0, 64'hFFFF_FFFF_FFFF_FFFF}, 128'd1, 1, 0, {64'd1, 64'd0});
    run("R1", enc_r(7'h20, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011), 1,
        {64'd1, 64'd0}, 128'd1, 1, 0, {64'd0, 64'hFFFF_FFFF_FFFF_FFFF});
    // R2 doubleword add wraps, no carry into high half; R3 junk ignored
    run("R2", enc_r(7'h00, 5'd2, 5'd1, 3'b000, 5'd4, 7'b1111011), 1,
        JUNK | 128'hFFFF_FFFF_FFFF_FFFF, JUNK | 128'd1, 1, 0, 128'd0);
    // R4 sign extension from bit 63
    run("R4", enc_r(7'h00, 5'd2, 5'd1, 3'b000, 5'd4, 7'b1111011), 1,
        JUNK | 128'h7FFF_FFFF_FFFF_FFFF, 128'd1, 1, 0, {64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000});
    run("R2", enc_r(7'h20, 5'd2, 5'd1, 3'b000, 5'd4, 7'b1111011), 1,
        JUNK, 128'd1, 1, 0, ONES);
    // R2 immediate sign-extended: 5 + (-1) = 4; R3 high garbage
    run("R3", enc_i(12'hFFF, 5'd1, 3'b000, 5'd5, 7'b1011011), 1,
        JUNK | 128'd5, 128'd0, 1, 0, 128'd4);
    // R5 shift masks: 0xFF -> 127, 0x7F -> 63, 0x3F -> 31
    run("R5", enc_r(7'h00, 5'd2, 5'd1, 3'b001, 5'd6, 7'b0110011), 1,
        128'd1, 128'hFF, 1, 0, {64'h8000_0000_0000_0000, 64'd0});
    run("R5", enc_r(7'h00, 5'd2, 5'd1, 3'b001, 5'd6, 7'b1111011), 1,
        128'd1, 128'h7F, 1, 0, {64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000});
    run("R5", enc_r(7'h00, 5'd2, 5'd1, 3'b001, 5'd6, 7'b0111011), 1,
        128'd1, 128'h3F, 1, 0, {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_8000_0000});
    // R4 word arithmetic right from bit 31
    run("R4", enc_r(7'h20, 5'd2, 5'd1, 3'b101, 5'd6, 7'b0111011), 1,
        JUNK | 128'h8000_0000, 128'd4, 1, 0, {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_F800_0000});
    // R6 doubleword gated by mode, malformed funct7
    run("R6", enc_r(7'h00, 5'd2, 5'd1, 3'b000, 5'd4, 7'b1111011), 0,
        128'd7, 128'd1, 1, 1, 128'd0);
    run("R6", enc_r(7'h01, 5'd2, 5'd1, 3'b000, 5'd4, 7'b0110011), 1,
        128'd7, 128'd1, 1, 1, 128'd0);
    // R7 zero registers
    run("R7", enc_r(7'h00, 5'd2, 5'd0, 3'b000, 5'd4, 7'b0110011), 1,
        ONES, 128'd5, 1, 0, 128'd5);
    run("R7", enc_r(7'h00, 5'd2, 5'd1, 3'b000, 5'd0, 7'b0110011), 1,
        128'd9, 128'd5, 1, 0, 128'd0);

    for (int k = 0; k < 400; k++) begin
      logic [6:0] ops [7] = '{7'b0110011, 7'b0010011, 7'b1111011, 7'b1011011,
                              7'b0111011, 7'b0011011, 7'b1100011};
      logic [2:0] f3s [4] = '{3'b000, 3'b001, 3'b101, 3'b010};
      logic [6:0] f7s [4] = '{7'h00, 7'h20, 7'h01, 7'h02};
      logic [6:0] op = ops[$urandom % 7];
      logic [31:0] ins = {f7s[$urandom % 4], 5'($urandom), 5'($urandom % 4),
                          f3s[$urandom % 4], 5'($urandom % 8), op};
      string tag = (op == 7'b1111011 || op == 7'b1011011) ? "R2" :
                   (op == 7'b0111011 || op == 7'b0011011) ? "R4" :
                   (op == 7'b1100011) ? "R6" : "R1";
      if ((k % 5) == 0) ins[25:20] = 6'($urandom);
      run(tag, ins, 1'($urandom), {$urandom, $urandom, $urandom, $urandom},
          {$urandom, $urandom, $urandom, $urandom});
    end
    finish_up();
  end
endmodule